// File: doc/BRIEF.md
# Dual-Mode Serial Memory Mode Sequencer

This block decides whether a small serial memory streams its contents out on its own, or answers a master over a two-wire bidirectional bus. After power-up it is in stream-out mode. On each rising edge of the stream clock pin it asks for one bit of the current byte, most significant bit first, and steps through the byte addresses in order. A falling edge on the bus clock while the data line is released moves it into a tentative bidirectional state. There a watchdog counts stream-clock edges. A master that gets an acknowledge for the correct device code locks the block into bidirectional mode until reset. A master that stays silent too long, or sends STOP in the middle of the slave address, sends the block back to stream-out mode from byte 00h.

All three pins are synchronized into the system clock domain and edge-detected there. The bus front end supplies two single-cycle flags that are synchronous to the system clock. The first marks an acknowledged device code; the front end raises it only for the 1010 code. The second marks a STOP received during the slave address.

Top module: `dual_mode_seq`

## Requirements
- R1: While reset is held and right after it, `mode_o` is 0 (stream-out; tentative is 1, locked is 2) and the stream pointer is at address 00h, bit 7.
- R2: In stream-out mode, a synchronized falling edge of SCL while SDA reads high moves the block to tentative. The same edge while SDA reads low is ignored and streaming goes on.
- R3: In tentative mode, each VCLK rising edge adds one to the watchdog count, and any SCL falling edge clears the count to zero, whatever SDA reads.
- R4: When the count reaches 128 VCLK rises in tentative mode with no acknowledge flag, the block returns to stream-out mode.
- R5: After such a return, the first stream slot falls on the next VCLK rise (the 129th) and carries address 00h, bit 7.
- R6: An acknowledge flag in tentative mode moves the block to locked mode. Locked mode is left only through reset; VCLK, SCL, SDA and the STOP flag have no effect on it.
- R7: The STOP-in-address flag in tentative mode returns the block to stream-out mode with the pointer back at 00h, bit 7.
- R8: In stream-out mode, `stream_en_o` pulses for one cycle per VCLK rise, with the bit index counting 7 down to 0. In tentative and locked mode it stays low.
- R9: The address steps by one after bit 0 of each byte is sent, and wraps from 7Fh to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-down) |
| vclk_i | input | 1 | Stream clock pin, asynchronous |
| scl_i | input | 1 | Two-wire bus clock as sampled, asynchronous |
| sda_i | input | 1 | Two-wire bus data as sampled, asynchronous |
| dev_ack_i | input | 1 | One-cycle flag: device code 1010 acknowledged |
| addr_stop_i | input | 1 | One-cycle flag: STOP seen during slave address |
| mode_o | output | 2 | 0 stream-out, 1 tentative, 2 locked |
| stream_en_o | output | 1 | One-cycle request to drive the addressed bit |
| stream_addr_o | output | 7 | Byte address being streamed |
| stream_bit_o | output | 3 | Bit index within the byte, 7 first |

## Verification
The bench clears the watchdog with an SCL edge partway through a count. It then checks that 127 further VCLK rises keep the block tentative and that the 128th does not. An off-by-one counter would leave tentative mode one edge early or one edge late. It also checks that the 128th edge produces no stream slot and that the 129th carries byte 00h, bit 7. A design that restarted late, or kept the old pointer, would show a wrong address or an extra pulse. The bench hammers locked mode with VCLK, SCL and STOP, where a lock that leaks would fall back to streaming. It also streams a full 128-byte lap to catch an address that fails to wrap.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [1:0] {
      MODE_TX   = 2'd0,
      MODE_TENT = 2'd1,
      MODE_LOCK = 2'd2
   } mode_e;
endpackage

// File: rtl/dmc_sync_edge.sv
module dmc_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dmc_sync_edge: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], din};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = level_o & ~prev_q;
   assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/dmc_vclk_watchdog.sv
module dmc_vclk_watchdog #(
   parameter int LIMIT = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic clear_i,
   input  logic tick_i,
   output logic expire_o
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("dmc_vclk_watchdog: LIMIT must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run_i || clear_i)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= cnt_q + 1'b1;
   end

   assign expire_o = run_i && tick_i && !clear_i && (cnt_q == LAST);

   // R3: a bus clock edge zeroes the count
   assert_count_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && clear_i) |=> (cnt_q == '0));
endmodule

// File: rtl/dmc_stream_ptr.sv
module dmc_stream_ptr #(
   parameter int ADDR_W = 7,
   parameter int BYTE_W = 8,
   localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart_i,
   input  logic              adv_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [BIT_W-1:0]  bit_o
);
   localparam logic [BIT_W-1:0] TOP_BIT = BIT_W'(BYTE_W - 1);

   logic [ADDR_W-1:0] addr_q;
   logic [BIT_W-1:0]  bit_q;

   generate
      if (ADDR_W < 1 || BYTE_W < 2) begin : g_bad_geom
         $error("dmc_stream_ptr: ADDR_W >= 1 and BYTE_W >= 2 required");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         bit_q  <= TOP_BIT;
      end else if (restart_i) begin
         addr_q <= '0;
         bit_q  <= TOP_BIT;
      end else if (adv_i) begin
         if (bit_q == '0) begin
            bit_q  <= TOP_BIT;
            addr_q <= addr_q + 1'b1;
         end else begin
            bit_q <= bit_q - 1'b1;
         end
      end
   end

   assign addr_o = addr_q;
   assign bit_o  = bit_q;

   // R9: the last bit of the top byte wraps to the first bit of byte 0
   assert_addr_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !restart_i && bit_q == '0 && (&addr_q)) |=> (addr_q == '0 && bit_q == TOP_BIT));
endmodule

// File: rtl/dual_mode_seq.sv
module dual_mode_seq
   import dmc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int WD_LIMIT    = 128,
   parameter int ADDR_W      = 7,
   parameter int BYTE_W      = 8,
   localparam int BIT_W      = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vclk_i,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              dev_ack_i,
   input  logic              addr_stop_i,
   output logic [1:0]        mode_o,
   output logic              stream_en_o,
   output logic [ADDR_W-1:0] stream_addr_o,
   output logic [BIT_W-1:0]  stream_bit_o
);
   mode_e mode_q, mode_d;
   logic  vclk_rise, scl_fall, sda_lvl, wd_expire, restart;
   logic  unused_vclk_lvl, unused_vclk_fall, unused_scl_lvl, unused_scl_rise;
   logic  unused_sda_rise, unused_sda_fall;

   dmc_sync_edge #(.STAGES(SYNC_STAGES)) u_vclk_sync (
      .clk(clk), .rst_n(rst_n), .din(vclk_i),
      .level_o(unused_vclk_lvl), .rise_o(vclk_rise), .fall_o(unused_vclk_fall));

   dmc_sync_edge #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .din(scl_i),
      .level_o(unused_scl_lvl), .rise_o(unused_scl_rise), .fall_o(scl_fall));

   dmc_sync_edge #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .din(sda_i),
      .level_o(sda_lvl), .rise_o(unused_sda_rise), .fall_o(unused_sda_fall));

   dmc_vclk_watchdog #(.LIMIT(WD_LIMIT)) u_watchdog (
      .clk(clk), .rst_n(rst_n),
      .run_i(mode_q == MODE_TENT), .clear_i(scl_fall), .tick_i(vclk_rise),
      .expire_o(wd_expire));

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_TX:   if (scl_fall && sda_lvl) mode_d = MODE_TENT;
         MODE_TENT: begin
            if (dev_ack_i)        mode_d = MODE_LOCK;
            else if (addr_stop_i) mode_d = MODE_TX;
            else if (wd_expire)   mode_d = MODE_TX;
         end
         MODE_LOCK: mode_d = MODE_LOCK;
         default:   mode_d = MODE_TX;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= MODE_TX;
      else        mode_q <= mode_d;
   end

   assign restart     = (mode_q == MODE_TENT) && (mode_d == MODE_TX);
   assign stream_en_o = vclk_rise && (mode_q == MODE_TX);
   assign mode_o      = mode_q;

   dmc_stream_ptr #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .restart_i(restart), .adv_i(stream_en_o),
      .addr_o(stream_addr_o), .bit_o(stream_bit_o));

   // R1: reset leaves the block in stream-out mode
   assert_reset_txonly_R1: assert property (@(posedge clk)
      !rst_n |=> (mode_q == MODE_TX));
   // R2: released-SDA clock edge enters tentative mode
   assert_enter_tent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_TX && scl_fall && sda_lvl) |=> (mode_q == MODE_TENT));
   // R4: watchdog expiry without acknowledge falls back
   assert_timeout_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_TENT && wd_expire && !dev_ack_i) |=> (mode_q == MODE_TX));
   // R6: acknowledge locks, and the lock holds
   assert_ack_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_TENT && dev_ack_i) |=> (mode_q == MODE_LOCK));
   assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_LOCK) |=> (mode_q == MODE_LOCK));
   // R7: STOP inside the slave address falls back
   assert_addr_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_TENT && addr_stop_i && !dev_ack_i) |=> (mode_q == MODE_TX));
endmodule

// File: tb/dual_mode_seq_bench.sv
module dual_mode_seq_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vclk = 1'b0, scl = 1'b1, sda = 1'b1, ack = 1'b0, astop = 1'b0;
   logic [1:0] mode;
   logic       s_en;
   logic [6:0] s_addr;
   logic [2:0] s_bit;

   int total = 0, bad = 0;
   int log_cnt = 0;
   logic [6:0] log_addr;
   logic [2:0] log_bit;
   bit done = 0;

   always #5 clk = ~clk;

   dual_mode_seq u_dual_mode_seq (
      .clk(clk), .rst_n(rst_n), .vclk_i(vclk), .scl_i(scl), .sda_i(sda),
      .dev_ack_i(ack), .addr_stop_i(astop), .mode_o(mode), .stream_en_o(s_en),
      .stream_addr_o(s_addr), .stream_bit_o(s_bit));

   always @(negedge clk) begin
      if (s_en) begin
         log_cnt  <= log_cnt + 1;
         log_addr <= s_addr;
         log_bit  <= s_bit;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk) rst_n = 1'b0;
      vclk = 0; scl = 1; sda = 1; ack = 0; astop = 0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic vclk_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         vclk = 1'b1; repeat (4) @(negedge clk);
         vclk = 1'b0; repeat (4) @(negedge clk);
      end
   endtask

   task automatic scl_fall(input logic sda_v);
      sda = sda_v; scl = 1'b1; repeat (4) @(negedge clk);
      scl = 1'b0; repeat (5) @(negedge clk);
      scl = 1'b1; sda = 1'b1; repeat (4) @(negedge clk);
   endtask

   task automatic flag_pulse(input bit is_ack);
      if (is_ack) ack = 1'b1; else astop = 1'b1;
      @(negedge clk);
      ack = 1'b0; astop = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset_R1();
      @(negedge clk) rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(mode == 2'd0, "R1 mode in reset", mode, 0);
      chk(s_addr == 7'h00 && s_bit == 3'd7, "R1 pointer in reset", {s_addr, s_bit}, 7);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(mode == 2'd0, "R1 mode after reset", mode, 0);
   endtask

   task automatic t_stream_R8();
      int c0;
      do_reset();
      c0 = log_cnt;
      for (int b = 7; b >= 0; b--) begin
         vclk_pulses(1);
         chk(log_bit == 3'(b) && log_addr == 7'h00, "R8 msb-first bit", log_bit, b);
      end
      chk(log_cnt == c0 + 8, "R8 one pulse per edge", log_cnt - c0, 8);
      vclk_pulses(1);
      chk(log_addr == 7'h01 && log_bit == 3'd7, "R9 next byte", log_addr, 1);
   endtask

   task automatic t_sda_low_R2();
      do_reset();
      scl_fall(1'b0);
      chk(mode == 2'd0, "R2 SDA low ignored", mode, 0);
      vclk_pulses(1);
      chk(log_addr == 7'h00 && log_bit == 3'd7, "R2 streaming continues", log_bit, 7);
      scl_fall(1'b1);
      chk(mode == 2'd1, "R2 enter tentative", mode, 1);
   endtask

   task automatic t_timeout_R4_R5();
      int c0;
      do_reset();
      vclk_pulses(3);
      scl_fall(1'b1);
      chk(mode == 2'd1, "R4 tentative", mode, 1);
      c0 = log_cnt;
      vclk_pulses(127);
      chk(mode == 2'd1, "R4 still tentative at 127", mode, 1);
      chk(log_cnt == c0, "R8 no stream in tentative", log_cnt - c0, 0);
      vclk_pulses(1);
      chk(mode == 2'd0, "R4 back at 128", mode, 0);
      chk(log_cnt == c0, "R5 no slot on 128th", log_cnt - c0, 0);
      vclk_pulses(1);
      chk(log_cnt == c0 + 1, "R5 slot on 129th", log_cnt - c0, 1);
      chk(log_addr == 7'h00 && log_bit == 3'd7, "R5 restart at 00h bit7",
          {log_addr, log_bit}, 7);
   endtask

   task automatic t_clear_R3();
      do_reset();
      scl_fall(1'b1);
      vclk_pulses(100);
      scl_fall(1'b0);
      chk(mode == 2'd1, "R3 tentative after clear", mode, 1);
      vclk_pulses(127);
      chk(mode == 2'd1, "R3 count restarted", mode, 1);
      vclk_pulses(1);
      chk(mode == 2'd0, "R3 expiry 128 after clear", mode, 0);
   endtask

   task automatic t_stop_R7();
      do_reset();
      vclk_pulses(10);
      scl_fall(1'b1);
      flag_pulse(1'b0);
      chk(mode == 2'd0, "R7 stop returns", mode, 0);
      vclk_pulses(1);
      chk(log_addr == 7'h00 && log_bit == 3'd7, "R7 pointer restarted",
          {log_addr, log_bit}, 7);
   endtask

   task automatic t_lock_R6();
      int c0;
      do_reset();
      scl_fall(1'b1);
      flag_pulse(1'b1);
      chk(mode == 2'd2, "R6 ack locks", mode, 2);
      c0 = log_cnt;
      vclk_pulses(200);
      scl_fall(1'b1);
      scl_fall(1'b0);
      flag_pulse(1'b0);
      chk(mode == 2'd2, "R6 lock holds", mode, 2);
      chk(log_cnt == c0, "R8 no stream when locked", log_cnt - c0, 0);
      do_reset();
      chk(mode == 2'd0, "R6 reset unlocks", mode, 0);
   endtask

   task automatic t_wrap_R9();
      do_reset();
      vclk_pulses(127 * 8 + 1);
      chk(log_addr == 7'h7f && log_bit == 3'd7, "R9 reached 7Fh", log_addr, 127);
      vclk_pulses(8);
      chk(log_addr == 7'h00 && log_bit == 3'd7, "R9 wrap to 00h", log_addr, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset_R1();
      t_stream_R8();
      t_sda_low_R2();
      t_timeout_R4_R5();
      t_clear_R3();
      t_stop_R7();
      t_lock_R6();
      t_wrap_R9();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule